// File: doc/BRIEF.md
# Interrupt Request Priority Resolver

This block holds the vector bookkeeping for one interrupt controller. It keeps three 256-bit sets: vectors that are pending, vectors that are in service, and vectors that arrived level-triggered. It also holds a task-priority value and derives the processor priority from it. Every clock, the highest pending vector that is not blocked by the processor priority is presented to the core. When the core acknowledges it, that vector moves from the pending set to the in-service set. An end-of-interrupt write retires the highest in-service vector. If that vector was level-triggered, the block sends a one-cycle broadcast carrying the vector number so that upstream sources can re-arm.

Vectors 0 to 15 are reserved. If one of them is the highest pending vector and is not blocked, it is never offered to the core. The block drops it, sets a sticky illegal-vector flag, and queues a programmable error vector in its place. A small register port lets software write the task priority and signal end-of-interrupt. It reads back the priorities, the flag, and all three vector sets as 32-bit words.

Top module: `irq_prio_resolver`

## Requirements
- R1: If the highest pending vector is below 16 and at least the processor priority, it is not offered in that cycle. At the next clock it is removed from the pending set, `err_vector` is added to the pending set, and bit 5 of the status word (address 3) becomes 1. The flag is sticky until reset, and `err_vector` is then offered like any other pending vector.
- R2: The processor priority (read at address 2) equals the task priority when task-priority bits 7:4 are greater than or equal to bits 7:4 of the highest in-service vector. Otherwise it equals those in-service bits 7:4 followed by four zero bits. An empty in-service set counts as class 0.
- R3: A request for a vector whose pending bit is already set changes nothing: the vector is not queued a second time and its trigger bit is not set.
- R4: A new request with `req_level`=1 sets the vector's trigger bit as well as its pending bit. With `req_level`=0 the trigger bit is left clear.
- R5: `int_valid` is 1 exactly when the highest pending vector is at least the processor priority and at least 16. `int_vector` is then that vector.
- R6: `ack_valid` while `int_valid`=1 sets the in-service bit of `int_vector` and clears its pending bit at that clock. `ack_valid` while `int_valid`=0 has no effect.
- R7: A write to address 1 clears the highest in-service bit. With an empty in-service set the write has no effect.
- R8: When the vector retired by R7 has its trigger bit set, that trigger bit is cleared. `eoi_bcast_valid` is 1 for exactly the cycle after the write, with `eoi_bcast_vector` equal to the retired vector. If the trigger bit was clear, no broadcast is sent.
- R9: A write to address 0 stores bits 7:0 of `reg_wdata` as the task priority. Reading address 0 returns that byte zero-extended.
- R10: If a request and an acknowledge name the same vector in one cycle, the acknowledge wins. The vector ends in service, not pending, and its trigger bit is not set.
- R11: The read map is as follows. Address 8+w returns pending vectors 32w to 32w+31, address 16+w returns in-service vectors, and address 24+w returns trigger vectors. Within each word, bit b is vector 32w+b. Address 1 reads as 0.
- R12: After reset, all three sets, the task priority, the processor priority and the flag are zero. `int_valid` and `eoi_bcast_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A vector is delivered this cycle |
| req_vector | input | 8 | Delivered vector number |
| req_level | input | 1 | Delivered vector is level-triggered |
| ack_valid | input | 1 | Core takes the offered vector |
| err_vector | input | 8 | Vector queued when a reserved vector is caught (16 or above) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| int_valid | output | 1 | A deliverable vector is offered |
| int_vector | output | 8 | Offered vector |
| eoi_bcast_valid | output | 1 | One-cycle level-triggered end-of-interrupt broadcast |
| eoi_bcast_vector | output | 8 | Vector being broadcast |

## Verification
The hardest situations to reach from the ports are those where two updates meet in one clock. The first is a request colliding with the acknowledge of the same vector. The second is an end-of-interrupt that must pick the higher of two stacked in-service vectors within one priority class. The bench builds both on purpose. It queues a vector, then raises request and acknowledge on that vector in the same cycle. It also nests a second acknowledge inside a class that is already in service before retiring. Reserved vectors are swept one at a time with the task priority at zero, so each one reaches the redirect path.

// File: rtl/irq_prio_pkg.sv
// Shared constants for the interrupt priority resolver: register word
// indices inside the scalar group, group codes and the status flag position.
package irq_prio_pkg;
    // Scalar register indices within group 0
    localparam int RA_TPR = 0;
    localparam int RA_EOI = 1;
    localparam int RA_PPR = 2;
    localparam int RA_ESR = 3;
    // Address groups (top two address bits)
    localparam logic [1:0] GRP_SCALAR  = 2'd0;
    localparam logic [1:0] GRP_PENDING = 2'd1;
    localparam logic [1:0] GRP_INSERV  = 2'd2;
    localparam logic [1:0] GRP_TRIGGER = 2'd3;
    // Status word bit flagging a caught reserved vector
    localparam int ESR_ILLEGAL_BIT = 5;
    // Highest reserved vector number plus one
    localparam int RSVD_LIMIT = 16;
endpackage

// File: rtl/vec_prio_enc.sv
// Highest-set-bit encoder over WIDTH bits, split into GROUP-wide slices.
// Each slice finds its own top bit, then the top non-empty slice is chosen.
// Assumes WIDTH and GROUP are powers of two with WIDTH/GROUP >= 2.
module vec_prio_enc #(
    parameter  int WIDTH = 256,
    parameter  int GROUP = 32,
    localparam int IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] bits_i,
    output logic             any_o,
    output logic [IDX_W-1:0] top_o
);
    localparam int NGRP  = WIDTH / GROUP;
    localparam int GRP_W = $clog2(GROUP);
    localparam int SEL_W = $clog2(NGRP);

    logic [NGRP-1:0]  grp_any;
    logic [GRP_W-1:0] grp_idx [NGRP];
    logic [SEL_W-1:0] sel;

    for (genvar g = 0; g < NGRP; g++) begin : g_slice
        logic [GRP_W-1:0] idx;
        // Top set bit inside this slice
        always_comb begin
            idx = '0;
            for (int i = 0; i < GROUP; i++) begin
                if (bits_i[g*GROUP + i]) idx = GRP_W'(i);
            end
        end
        assign grp_idx[g] = idx;
        assign grp_any[g] = |bits_i[g*GROUP +: GROUP];
    end

    // Top non-empty slice
    always_comb begin
        sel = '0;
        for (int g = 0; g < NGRP; g++) begin
            if (grp_any[g]) sel = SEL_W'(g);
        end
    end

    assign any_o = |grp_any;
    assign top_o = {sel, grp_idx[sel]};
endmodule

// File: rtl/ppr_calc.sv
// Processor priority: the task priority, unless the in-service class
// (upper half of the vector) is higher, in which case that class with a
// zero lower half. Purely combinational.
module ppr_calc #(
    parameter  int VEC_W = 8,
    localparam int CLS_W = VEC_W / 2
) (
    input  logic [VEC_W-1:0] tpr_i,
    input  logic             isr_any_i,
    input  logic [CLS_W-1:0] isr_cls_i,
    output logic [VEC_W-1:0] ppr_o
);
    logic [CLS_W-1:0] tpr_cls;
    logic [CLS_W-1:0] srv_cls;

    // Compare classes and pick the priority floor
    always_comb begin
        tpr_cls = tpr_i[VEC_W-1 -: CLS_W];
        srv_cls = isr_any_i ? isr_cls_i : '0;
        if (tpr_cls >= srv_cls) ppr_o = tpr_i;
        else                    ppr_o = {srv_cls, {(VEC_W-CLS_W){1'b0}}};
    end
endmodule

// File: rtl/reg_rd_mux.sv
// Read-data selector for the register port. The upper two address bits
// select a group (scalars, pending, in-service, trigger) and the lower bits
// a word within it. Assumes at least four words per vector set.
module reg_rd_mux
    import irq_prio_pkg::*;
#(
    parameter  int NUM_VEC   = 256,
    parameter  int WORD_W    = 32,
    localparam int VEC_W     = $clog2(NUM_VEC),
    localparam int NUM_WORDS = NUM_VEC / WORD_W,
    localparam int WSEL_W    = $clog2(NUM_WORDS),
    localparam int ADDR_W    = WSEL_W + 2
) (
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [VEC_W-1:0]   tpr_i,
    input  logic [VEC_W-1:0]   ppr_i,
    input  logic [VEC_W-1:0]   esr_i,
    input  logic [NUM_VEC-1:0] irr_i,
    input  logic [NUM_VEC-1:0] isr_i,
    input  logic [NUM_VEC-1:0] tmr_i,
    output logic [WORD_W-1:0]  rdata_o
);
    logic [WSEL_W-1:0] widx;
    logic [1:0]        grp;

    assign widx = addr_i[WSEL_W-1:0];
    assign grp  = addr_i[ADDR_W-1 -: 2];

    // Select the addressed word
    always_comb begin
        rdata_o = '0;
        case (grp)
            GRP_SCALAR: begin
                if (widx == WSEL_W'(RA_TPR))      rdata_o = WORD_W'(tpr_i);
                else if (widx == WSEL_W'(RA_PPR)) rdata_o = WORD_W'(ppr_i);
                else if (widx == WSEL_W'(RA_ESR)) rdata_o = WORD_W'(esr_i);
                else                              rdata_o = '0;
            end
            GRP_PENDING: rdata_o = irr_i[widx*WORD_W +: WORD_W];
            GRP_INSERV:  rdata_o = isr_i[widx*WORD_W +: WORD_W];
            default:     rdata_o = tmr_i[widx*WORD_W +: WORD_W];
        endcase
    end
endmodule

// File: rtl/irq_prio_resolver.sv
// Interrupt request priority resolver. Holds the pending, in-service and
// trigger vector sets plus the task priority, offers the highest deliverable
// vector, moves it to service on acknowledge, retires on end-of-interrupt
// and broadcasts level-triggered retirements. One request and one
// acknowledge per clock; the acknowledge wins a same-vector collision.
// Assumes err_vector is not a reserved vector.
module irq_prio_resolver
    import irq_prio_pkg::*;
#(
    parameter  int NUM_VEC   = 256,
    parameter  int WORD_W    = 32,
    localparam int VEC_W     = $clog2(NUM_VEC),
    localparam int NUM_WORDS = NUM_VEC / WORD_W,
    localparam int WSEL_W    = $clog2(NUM_WORDS),
    localparam int ADDR_W    = WSEL_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VEC_W-1:0]  req_vector,
    input  logic              req_level,
    input  logic              ack_valid,
    input  logic [VEC_W-1:0]  err_vector,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              int_valid,
    output logic [VEC_W-1:0]  int_vector,
    output logic              eoi_bcast_valid,
    output logic [VEC_W-1:0]  eoi_bcast_vector
);
    localparam int CLS_W = VEC_W / 2;
    localparam logic [VEC_W-1:0]  RSVD_V   = VEC_W'(RSVD_LIMIT);
    localparam logic [ADDR_W-1:0] ADDR_TPR = ADDR_W'(RA_TPR);
    localparam logic [ADDR_W-1:0] ADDR_EOI = ADDR_W'(RA_EOI);

    logic [NUM_VEC-1:0] irr_q, irr_d;
    logic [NUM_VEC-1:0] isr_q, isr_d;
    logic [NUM_VEC-1:0] tmr_q, tmr_d;
    logic [VEC_W-1:0]   tpr_q;
    logic               esr_q;
    logic               bcast_q;
    logic [VEC_W-1:0]   bcast_vec_q;

    logic               irr_any, isr_any;
    logic [VEC_W-1:0]   irr_top, isr_top;
    logic [VEC_W-1:0]   ppr;
    logic [VEC_W-1:0]   esr_word;
    logic               top_ok, redirect, do_ack, do_eoi, req_new, tpr_wr;
    logic               unused_wdata_hi;

    assign unused_wdata_hi = ^reg_wdata[WORD_W-1:VEC_W];

    vec_prio_enc #(.WIDTH(NUM_VEC), .GROUP(WORD_W)) u_irr_enc (
        .bits_i (irr_q),
        .any_o  (irr_any),
        .top_o  (irr_top)
    );

    vec_prio_enc #(.WIDTH(NUM_VEC), .GROUP(WORD_W)) u_isr_enc (
        .bits_i (isr_q),
        .any_o  (isr_any),
        .top_o  (isr_top)
    );

    ppr_calc #(.VEC_W(VEC_W)) u_ppr (
        .tpr_i     (tpr_q),
        .isr_any_i (isr_any),
        .isr_cls_i (isr_top[VEC_W-1 -: CLS_W]),
        .ppr_o     (ppr)
    );

    // Status word with the sticky illegal-vector flag in place
    always_comb begin
        esr_word = '0;
        esr_word[ESR_ILLEGAL_BIT] = esr_q;
    end

    reg_rd_mux #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_rd (
        .addr_i  (reg_addr),
        .tpr_i   (tpr_q),
        .ppr_i   (ppr),
        .esr_i   (esr_word),
        .irr_i   (irr_q),
        .isr_i   (isr_q),
        .tmr_i   (tmr_q),
        .rdata_o (reg_rdata)
    );

    // Offer decision and per-cycle events
    always_comb begin
        top_ok    = irr_any && (irr_top >= ppr);
        redirect  = top_ok && (irr_top < RSVD_V);
        int_valid = top_ok && !redirect;
        do_ack    = ack_valid && int_valid;
        do_eoi    = reg_wr && (reg_addr == ADDR_EOI) && isr_any;
        tpr_wr    = reg_wr && (reg_addr == ADDR_TPR);
        req_new   = req_valid && !irr_q[req_vector];
    end

    assign int_vector = irr_top;

    // Next state of the pending set
    always_comb begin
        irr_d = irr_q;
        if (req_new) irr_d[req_vector] = 1'b1;
        if (redirect) begin
            irr_d[irr_top]    = 1'b0;
            irr_d[err_vector] = 1'b1;
        end
        if (do_ack) irr_d[irr_top] = 1'b0;
    end

    // Next state of the in-service set: retire first, then acknowledge
    always_comb begin
        isr_d = isr_q;
        if (do_eoi) isr_d[isr_top] = 1'b0;
        if (do_ack) isr_d[irr_top] = 1'b1;
    end

    // Next state of the trigger set: retire clear, then new level request
    always_comb begin
        tmr_d = tmr_q;
        if (do_eoi && tmr_q[isr_top]) tmr_d[isr_top] = 1'b0;
        if (req_new && req_level)     tmr_d[req_vector] = 1'b1;
    end

    // Vector sets
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr_q <= '0;
            isr_q <= '0;
            tmr_q <= '0;
        end else begin
            irr_q <= irr_d;
            isr_q <= isr_d;
            tmr_q <= tmr_d;
        end
    end

    // Task priority and sticky illegal-vector flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tpr_q <= '0;
            esr_q <= 1'b0;
        end else begin
            if (tpr_wr)   tpr_q <= reg_wdata[VEC_W-1:0];
            if (redirect) esr_q <= 1'b1;
        end
    end

    // Level-triggered end-of-interrupt broadcast pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bcast_q     <= 1'b0;
            bcast_vec_q <= '0;
        end else begin
            bcast_q <= do_eoi && tmr_q[isr_top];
            if (do_eoi) bcast_vec_q <= isr_top;
        end
    end

    assign eoi_bcast_valid  = bcast_q;
    assign eoi_bcast_vector = bcast_vec_q;
endmodule

// File: rtl/irq_prio_resolver_chk.sv
// Property checker for the interrupt priority resolver, attached by bind.
// Observes ports and the vector-set state; drives nothing.
module irq_prio_resolver_chk
    import irq_prio_pkg::*;
#(
    parameter  int NUM_VEC   = 256,
    parameter  int WORD_W    = 32,
    localparam int VEC_W     = $clog2(NUM_VEC),
    localparam int NUM_WORDS = NUM_VEC / WORD_W,
    localparam int WSEL_W    = $clog2(NUM_WORDS),
    localparam int ADDR_W    = WSEL_W + 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ack_valid,
    input logic               reg_wr,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [WORD_W-1:0]  reg_wdata,
    input logic               int_valid,
    input logic [VEC_W-1:0]   int_vector,
    input logic               eoi_bcast_valid,
    input logic [VEC_W-1:0]   ppr,
    input logic [VEC_W-1:0]   tpr_q,
    input logic [NUM_VEC-1:0] irr_q,
    input logic [NUM_VEC-1:0] isr_q,
    input logic               isr_any,
    input logic [VEC_W-1:0]   isr_top
);
    localparam logic [VEC_W-1:0]  CLS_MASK = {{(VEC_W/2){1'b1}}, {(VEC_W-VEC_W/2){1'b0}}};
    localparam logic [VEC_W-1:0]  RSVD_V   = VEC_W'(RSVD_LIMIT);
    localparam logic [ADDR_W-1:0] ADDR_TPR = ADDR_W'(RA_TPR);
    localparam logic [ADDR_W-1:0] ADDR_EOI = ADDR_W'(RA_EOI);
    localparam logic [WORD_W-1:0] TPR_MASK = WORD_W'({VEC_W{1'b1}});

    AST_OFFER_ABOVE_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        int_valid |-> (int_vector >= ppr) && (int_vector >= RSVD_V)); // R5

    AST_ACK_MOVES_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && int_valid) |=> isr_q[$past(int_vector)] && !irr_q[$past(int_vector)]); // R6

    AST_EOI_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_EOI && !isr_any && !(ack_valid && int_valid))
        |=> !eoi_bcast_valid && (isr_q == $past(isr_q))); // R7

    AST_PPR_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (ppr >= (tpr_q & CLS_MASK)) && (!isr_any || ppr >= (isr_top & CLS_MASK))); // R2

    AST_TPR_LOW_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_TPR) |=> WORD_W'(tpr_q) == ($past(reg_wdata) & TPR_MASK)); // R9
endmodule

bind irq_prio_resolver irq_prio_resolver_chk #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_chk (.*);

// File: tb/irq_prio_resolver_tb.sv
// Self-checking bench: sweeps every legal vector edge and level, every
// reserved vector, every task priority, and the collision corner cases.
module irq_prio_resolver_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_level, ack_valid, reg_wr;
    logic [7:0]  req_vector, err_vector;
    logic [4:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        int_valid, eoi_bcast_valid;
    logic [7:0]  int_vector, eoi_bcast_vector;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [4:0] A_TPR = 5'd0, A_EOI = 5'd1, A_PPR = 5'd2, A_ESR = 5'd3;
    localparam logic [1:0] G_PEND = 2'd1, G_SERV = 2'd2, G_TRIG = 2'd3;

    always #4 clk = ~clk;

    irq_prio_resolver u_dut (
        .clk, .rst_n, .req_valid, .req_vector, .req_level, .ack_valid,
        .err_vector, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
        .int_valid, .int_vector, .eoi_bcast_valid, .eoi_bcast_vector
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Read with inputs idle; realigns to the next falling edge
    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
        @(negedge clk);
    endtask

    task automatic chk_reg(input string req, input logic [4:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        chk(req, d, exp);
    endtask

    task automatic chk_word(input string req, input logic [1:0] g, input logic [7:0] v,
                            input logic [31:0] exp);
        chk_reg(req, {g, v[7:5]}, exp);
    endtask

    function automatic logic [31:0] bitw(input logic [7:0] v);
        return 32'd1 << v[4:0];
    endfunction

    task automatic accept(input logic [7:0] v, input logic lvl);
        req_valid = 1'b1; req_vector = v; req_level = lvl;
        tick();
        req_valid = 1'b0; req_level = 1'b0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic ack1();
        ack_valid = 1'b1;
        tick();
        ack_valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_level = 1'b0; ack_valid = 1'b0;
        reg_wr = 1'b0; req_vector = '0; err_vector = 8'hE3; reg_addr = '0; reg_wdata = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R12: reset state
        chk("R12 int_valid", 32'(int_valid), 0);
        chk("R12 bcast", 32'(eoi_bcast_valid), 0);
        for (int g = 1; g < 4; g++)
            for (int w = 0; w < 8; w++)
                chk_reg("R12 set word", 5'(g*8 + w), 0);
        chk_reg("R12 tpr", A_TPR, 0);
        chk_reg("R12 ppr", A_PPR, 0);
        chk_reg("R12 esr", A_ESR, 0);

        // R4 R5 R6 R7 R8 R11: every legal vector, edge then level
        for (int v = 16; v < 256; v++) begin
            for (int lvl = 0; lvl < 2; lvl++) begin
                accept(8'(v), 1'(lvl));
                chk("R5 offered", 32'(int_valid), 1);
                chk("R5 vector", 32'(int_vector), 32'(v));
                chk_word("R11 pending word", G_PEND, 8'(v), bitw(8'(v)));
                chk_word("R4 trigger bit", G_TRIG, 8'(v), lvl ? bitw(8'(v)) : 0);
                ack1();
                chk("R6 offer gone", 32'(int_valid), 0);
                chk_word("R6 in service", G_SERV, 8'(v), bitw(8'(v)));
                chk_word("R6 pending clear", G_PEND, 8'(v), 0);
                chk_reg("R2 ppr from service", A_PPR, 32'(v & 8'hF0));
                wr(A_EOI, 0);
                chk("R8 bcast valid", 32'(eoi_bcast_valid), 32'(lvl));
                if (lvl) chk("R8 bcast vector", 32'(eoi_bcast_vector), 32'(v));
                tick();
                chk("R8 one cycle", 32'(eoi_bcast_valid), 0);
                chk_word("R7 retired", G_SERV, 8'(v), 0);
                chk_word("R8 trigger cleared", G_TRIG, 8'(v), 0);
            end
        end

        // R9 R2 R5: task priority sweep against pending 0x80
        accept(8'h80, 1'b0);
        for (int t = 0; t < 256; t++) begin
            wr(A_TPR, 32'hA5A5_5A00 | 32'(t));
            chk("R5 gate", 32'(int_valid), (t <= 8'h80) ? 1 : 0);
            chk_reg("R9 tpr byte", A_TPR, 32'(t));
            chk_reg("R2 ppr equals tpr", A_PPR, 32'(t));
        end
        wr(A_TPR, 0);
        ack1();
        wr(A_EOI, 0);

        // R2: in-service class 5 against every task priority
        accept(8'h50, 1'b0);
        ack1();
        for (int t = 0; t < 256; t++) begin
            wr(A_TPR, 32'(t));
            chk_reg("R2 class compare", A_PPR, ((t >> 4) >= 5) ? 32'(t) : 32'h50);
        end
        wr(A_TPR, 0);
        wr(A_EOI, 0);
        tick();

        // R3: duplicate request
        accept(8'h60, 1'b0);
        accept(8'h60, 1'b1);
        chk_word("R3 no trigger on duplicate", G_TRIG, 8'h60, 0);
        ack1();
        chk("R3 queued once", 32'(int_valid), 0);
        chk_word("R3 pending empty", G_PEND, 8'h60, 0);
        wr(A_EOI, 0);
        chk("R3 no bcast", 32'(eoi_bcast_valid), 0);
        tick();

        // R10: request and acknowledge of the same vector together
        accept(8'h70, 1'b0);
        req_valid = 1'b1; req_vector = 8'h70; req_level = 1'b1; ack_valid = 1'b1;
        tick();
        req_valid = 1'b0; req_level = 1'b0; ack_valid = 1'b0;
        chk("R10 not offered", 32'(int_valid), 0);
        chk_word("R10 pending", G_PEND, 8'h70, 0);
        chk_word("R10 in service", G_SERV, 8'h70, bitw(8'h70));
        chk_word("R10 trigger", G_TRIG, 8'h70, 0);
        wr(A_EOI, 0);
        tick();

        // R5 R7: stacked priorities
        accept(8'h40, 1'b0);
        accept(8'h90, 1'b0);
        accept(8'h30, 1'b0);
        chk("R5 highest", 32'(int_vector), 32'h90);
        ack1();
        chk("R5 blocked below ppr", 32'(int_valid), 0);
        wr(A_EOI, 0);
        chk("R7 next offered", 32'(int_vector), 32'h40);
        chk("R7 next valid", 32'(int_valid), 1);
        ack1();
        chk("R5 0x30 blocked", 32'(int_valid), 0);
        accept(8'h45, 1'b0);
        chk("R5 same class offered", 32'(int_vector), 32'h45);
        ack1();
        wr(A_EOI, 0);
        chk_word("R7 highest of class retired", G_SERV, 8'h40, bitw(8'h40));
        chk_reg("R2 ppr after retire", A_PPR, 32'h40);
        wr(A_EOI, 0);
        chk("R7 low vector offered", 32'(int_vector), 32'h30);
        ack1();
        wr(A_EOI, 0);
        tick();

        // R7: end-of-interrupt with nothing in service
        wr(A_EOI, 0);
        chk("R7 empty no bcast", 32'(eoi_bcast_valid), 0);
        chk_word("R7 empty set", G_SERV, 8'h30, 0);
        chk_reg("R7 empty ppr", A_PPR, 0);

        // R6: acknowledge with nothing offered
        ack1();
        chk_word("R6 idle ack", G_SERV, 8'h30, 0);

        // R1: every reserved vector is redirected
        for (int v = 0; v < 16; v++) begin
            accept(8'(v), 1'b0);
            chk("R1 not offered", 32'(int_valid), 0);
            tick();
            chk("R1 err offered", 32'(int_valid), 1);
            chk("R1 err vector", 32'(int_vector), 32'hE3);
            chk_word("R1 reserved dropped", G_PEND, 8'(v), 0);
            chk_word("R1 err pending", G_PEND, 8'hE3, bitw(8'hE3));
            chk_reg("R1 status bit", A_ESR, 32'h20);
            ack1();
            wr(A_EOI, 0);
            tick();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule